// File: doc/BRIEF.md
# Copy-Control Line Data Inserter

This block holds a small copy-management packet and sends it as a serial bit stream on one video line of every frame. A host writes the packet, the target line number and a start delay into a bank of byte-wide staging registers. Nothing the host writes reaches the output until it writes the top register of the bank with its enable bit set. That write arms a pending copy, and the copy becomes live at the next frame start. A packet that is only partly written is therefore never sent.

On the selected line the block waits a programmed number of sample clocks after line start. It then shifts the 20-bit payload out MSB first and raises a valid flag for the whole burst. Each bit lasts two sample clocks in 1x timing and four in 2x interpolated timing. The timing mode is sampled when the line starts.

Top module: `cgms_inserter`

## Requirements
- R1: After reset `cgms_valid` and `cgms_bit` are low, and no line is sent until a first commit has taken place.
- R2: The register map is as follows. Address 0 holds the line number bits [7:0]. Address 1 bits [1:0] hold line number bits [9:8]. Address 2 holds the start delay in sample clocks. Address 3 holds payload bits [7:0] and address 4 holds payload bits [15:8]. Address 5 is the top register: bits [3:0] hold payload bits [19:16] and bit 7 is the enable bit.
- R3: A write to address 5 with bit 7 set takes a copy of the whole staged bank, including the data of that same write. The copy becomes the live packet at the next `frame_start`.
- R4: Writes to addresses 0 to 4, and writes to address 5 with bit 7 clear, leave the transmitted packet, line and delay unchanged.
- R5: A commit made at any point in a frame, including during an inserted line, takes effect only at the next `frame_start`. A line start in the same cycle as that `frame_start` already uses the newly committed values.
- R6: At most one line per frame is inserted. Only the first `line_start` with `line_cnt` equal to the live line number starts a burst.
- R7: When `line_start` is sampled at edge e0, `cgms_valid` is first high after edge e0+D+1, where D is the start delay. The 20 payload bits follow MSB first.
- R8: Each bit lasts 2 sample clocks when `mode_2x` is 0 and 4 sample clocks when `mode_2x` is 1. The value of `mode_2x` is taken at the starting `line_start`.
- R9: Bits [6:4] of the top register have no effect on the output.
- R10: `cgms_bit` is 0 whenever `cgms_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| frame_start | input | 1 | One-cycle pulse at frame start |
| line_start | input | 1 | One-cycle pulse at line start |
| line_cnt | input | 10 | Current line number |
| mode_2x | input | 1 | 1 selects 2x interpolated bit timing |
| cgms_bit | output | 1 | Serial payload bit |
| cgms_valid | output | 1 | High while payload bits are on `cgms_bit` |

## Verification
The bench runs complete frames and varies one thing at a time: the payload values, the start delay (including zero), the timing mode, and the moment a commit arrives. A commit before the frame checks the plain commit path. A commit during an inserted line must leave that line intact. A commit in a frame whose selected line shares its cycle with frame start checks the same-cycle bypass. A frame whose line counter repeats a value checks that only one line is sent per frame. Top-register writes with the enable bit clear, and writes to the lower registers only, check that staging alone never reaches the output.

// File: rtl/cgms_pkg.sv
package cgms_pkg;

    localparam int CG_LINE_W   = 10;
    localparam int CG_OFS_W    = 8;
    localparam int CG_PAY_W    = 20;
    localparam int CG_BIT_CLKS = 2;
    localparam int CG_ADDR_W   = 3;

    localparam int CG_FULL_BYTES = CG_PAY_W / 8;
    localparam int CG_REM_BITS   = CG_PAY_W - 8 * CG_FULL_BYTES;
    localparam int CG_HI_BITS    = CG_LINE_W - 8;

    localparam logic [CG_ADDR_W-1:0] CG_A_LINE_LO = 3'd0;
    localparam logic [CG_ADDR_W-1:0] CG_A_LINE_HI = 3'd1;
    localparam logic [CG_ADDR_W-1:0] CG_A_OFS     = 3'd2;
    localparam int                   CG_A_PAY0    = 3;
    localparam logic [CG_ADDR_W-1:0] CG_A_TOP     = CG_ADDR_W'(CG_A_PAY0 + CG_FULL_BYTES);
    localparam int                   CG_EN_BIT    = 7;

    typedef struct packed {
        logic                 en;
        logic [CG_LINE_W-1:0] line;
        logic [CG_OFS_W-1:0]  ofs;
        logic [CG_PAY_W-1:0]  pay;
    } cg_cfg_t;

    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_WAIT  = 2'd1,
        SER_SHIFT = 2'd2
    } ser_state_e;

    function automatic int unsigned bit_period(input logic two_x);
        return two_x ? 2 * CG_BIT_CLKS : CG_BIT_CLKS;
    endfunction

endpackage

// File: rtl/cgms_regbank.sv
module cgms_regbank
    import cgms_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [CG_ADDR_W-1:0] wr_addr,
    input  logic [7:0]           wr_data,
    input  logic                 frame_start,
    output cg_cfg_t              cfg_eff
);

    logic [7:0]            line_lo_q;
    logic [CG_HI_BITS-1:0] line_hi_q;
    logic [CG_OFS_W-1:0]   ofs_q;
    logic [7:0]            pay_byte_q [CG_FULL_BYTES];
    logic [CG_REM_BITS-1:0] pay_top_q;
    logic [CG_PAY_W-1:0]   stg_pay;

    cg_cfg_t snap;
    cg_cfg_t pend_cfg_q;
    cg_cfg_t live_q;
    logic    pend_q;

    logic top_wr;
    logic commit_req;

    assign top_wr     = wr_en && (wr_addr == CG_A_TOP);
    assign commit_req = top_wr && wr_data[CG_EN_BIT];

    // staging of scalar fields
    always_ff @(posedge clk) begin
        if (rst) begin
            line_lo_q <= '0;
            line_hi_q <= '0;
            ofs_q     <= '0;
            pay_top_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == CG_A_LINE_LO) line_lo_q <= wr_data;
            if (wr_addr == CG_A_LINE_HI) line_hi_q <= wr_data[CG_HI_BITS-1:0];
            if (wr_addr == CG_A_OFS)     ofs_q     <= wr_data[CG_OFS_W-1:0];
            if (top_wr)                  pay_top_q <= wr_data[CG_REM_BITS-1:0];
        end
    end

    // staging of full payload bytes
    for (genvar gi = 0; gi < CG_FULL_BYTES; gi++) begin : g_pay_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                pay_byte_q[gi] <= '0;
            end else if (wr_en && (wr_addr == CG_ADDR_W'(CG_A_PAY0 + gi))) begin
                pay_byte_q[gi] <= wr_data;
            end
        end
        assign stg_pay[8*gi +: 8] = pay_byte_q[gi];
    end

    assign stg_pay[CG_PAY_W-1 -: CG_REM_BITS] = pay_top_q;

    // copy of the bank as it stands including the committing write
    always_comb begin
        snap      = '0;
        snap.en   = 1'b1;
        snap.line = {line_hi_q, line_lo_q};
        snap.ofs  = ofs_q;
        snap.pay  = stg_pay;
        snap.pay[CG_PAY_W-1 -: CG_REM_BITS] = wr_data[CG_REM_BITS-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            pend_cfg_q <= '0;
            live_q     <= '0;
        end else begin
            if (commit_req) begin
                pend_q     <= 1'b1;
                pend_cfg_q <= snap;
            end else if (frame_start) begin
                pend_q <= 1'b0;
            end
            if (frame_start && pend_q) begin
                live_q <= pend_cfg_q;
            end
        end
    end

    // a frame start that promotes a pending copy already sees it
    assign cfg_eff = (frame_start && pend_q) ? pend_cfg_q : live_q;

    // R4 / R5: live packet moves only on a frame start
    a_r5_live_hold: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(live_q));

    // R4: a frame start without a pending commit changes nothing
    a_r4_no_pending_no_change: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !pend_q) |=> $stable(live_q));

    // R3: a pending commit is consumed by the frame start
    a_r3_pending_consumed: assert property (@(posedge clk) disable iff (rst)
        (frame_start && pend_q && !commit_req) |=> (!pend_q && live_q.en));

endmodule

// File: rtl/cgms_serializer.sv
module cgms_serializer
    import cgms_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frame_start,
    input  logic                 line_start,
    input  logic [CG_LINE_W-1:0] line_cnt,
    input  logic                 mode_2x,
    input  cg_cfg_t              cfg,
    output logic                 out_bit,
    output logic                 out_valid
);

    localparam int PH_W  = (2 * CG_BIT_CLKS > 1) ? $clog2(2 * CG_BIT_CLKS) : 1;
    localparam int BIT_W = $clog2(CG_PAY_W);

    ser_state_e            state_q;
    logic [CG_OFS_W-1:0]   dly_q;
    logic [PH_W-1:0]       ph_q;
    logic [PH_W-1:0]       per_m1_q;
    logic [BIT_W-1:0]      bcnt_q;
    logic [CG_PAY_W-1:0]   sh_q;
    logic                  done_q;
    logic [1:0]            starts_q;
    logic                  go;

    assign go = (state_q == SER_IDLE) && line_start && cfg.en &&
                (line_cnt == cfg.line) && (frame_start || !done_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SER_IDLE;
            dly_q    <= '0;
            ph_q     <= '0;
            per_m1_q <= '0;
            bcnt_q   <= '0;
            sh_q     <= '0;
            done_q   <= 1'b0;
        end else begin
            if (go) begin
                done_q <= 1'b1;
            end else if (frame_start) begin
                done_q <= 1'b0;
            end
            case (state_q)
                SER_IDLE: begin
                    if (go) begin
                        state_q  <= SER_WAIT;
                        dly_q    <= cfg.ofs;
                        sh_q     <= cfg.pay;
                        per_m1_q <= PH_W'(bit_period(mode_2x) - 1);
                        ph_q     <= '0;
                        bcnt_q   <= '0;
                    end
                end
                SER_WAIT: begin
                    if (dly_q == '0) begin
                        state_q <= SER_SHIFT;
                    end else begin
                        dly_q <= dly_q - 1'b1;
                    end
                end
                SER_SHIFT: begin
                    if (ph_q == per_m1_q) begin
                        ph_q <= '0;
                        sh_q <= {sh_q[CG_PAY_W-2:0], 1'b0};
                        if (bcnt_q == BIT_W'(CG_PAY_W - 1)) begin
                            state_q <= SER_IDLE;
                        end else begin
                            bcnt_q <= bcnt_q + 1'b1;
                        end
                    end else begin
                        ph_q <= ph_q + 1'b1;
                    end
                end
                default: state_q <= SER_IDLE;
            endcase
        end
    end

    assign out_valid = (state_q == SER_SHIFT);
    assign out_bit   = out_valid & sh_q[CG_PAY_W-1];

    // burst starts seen since the last frame start
    always_ff @(posedge clk) begin
        if (rst) begin
            starts_q <= '0;
        end else if (frame_start) begin
            starts_q <= {1'b0, go};
        end else if (go && starts_q != 2'd3) begin
            starts_q <= starts_q + 1'b1;
        end
    end

    // R6: never more than one inserted line per frame
    a_r6_one_line: assert property (@(posedge clk) disable iff (rst)
        starts_q <= 2'd1);

    // R7: the burst is always preceded by the delay phase
    a_r7_wait_first: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> ($past(state_q) == SER_WAIT));

    // R8: a bit is held for its full period
    a_r8_bit_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ph_q != '0) |-> $stable(out_bit));

    // R1: output activity needs an enabled live packet
    a_r1_valid_needs_en: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> cfg.en);

endmodule

// File: rtl/cgms_inserter.sv
module cgms_inserter
    import cgms_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [CG_ADDR_W-1:0] wr_addr,
    input  logic [7:0]           wr_data,
    input  logic                 frame_start,
    input  logic                 line_start,
    input  logic [CG_LINE_W-1:0] line_cnt,
    input  logic                 mode_2x,
    output logic                 cgms_bit,
    output logic                 cgms_valid
);

    cg_cfg_t cfg_eff;

    cgms_regbank u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .frame_start (frame_start),
        .cfg_eff     (cfg_eff)
    );

    cgms_serializer u_ser (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .line_start  (line_start),
        .line_cnt    (line_cnt),
        .mode_2x     (mode_2x),
        .cfg         (cfg_eff),
        .out_bit     (cgms_bit),
        .out_valid   (cgms_valid)
    );

    // R10: no stray data bit outside a burst
    a_r10_quiet_outside: assert property (@(posedge clk) disable iff (rst)
        $fell(cgms_valid) |-> !cgms_bit);

endmodule

// File: tb/cgms_inserter_tb.sv
module cgms_inserter_tb;

    localparam int LLEN = 100;
    localparam int NL   = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       frame_start = 1'b0;
    logic       line_start = 1'b0;
    logic [9:0] line_cnt = '0;
    logic       mode_2x = 1'b0;
    logic       cgms_bit;
    logic       cgms_valid;

    int checks = 0;
    int errors = 0;
    int vcnt   = 0;
    bit started = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    cgms_inserter u_dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .frame_start (frame_start),
        .line_start  (line_start),
        .line_cnt    (line_cnt),
        .mode_2x     (mode_2x),
        .cgms_bit    (cgms_bit),
        .cgms_valid  (cgms_valid)
    );

    // ---------------- behavioural reference model ----------------
    bit [7:0]  s_lo, s_ofs;
    bit [1:0]  s_hi;
    bit [19:0] s_pay;
    bit        l_en;
    int        l_line, l_ofs;
    bit [19:0] l_pay;
    bit        p_ok;
    int        p_line, p_ofs;
    bit [19:0] p_pay;
    bit        m_done;
    bit [1:0]  q[$];
    bit        exp_v, exp_b;

    always @(posedge clk) begin
        if (rst) begin
            s_lo = 0; s_hi = 0; s_ofs = 0; s_pay = 0;
            l_en = 0; l_line = 0; l_ofs = 0; l_pay = 0;
            p_ok = 0; p_line = 0; p_ofs = 0; p_pay = 0;
            m_done = 0; q.delete(); exp_v = 0; exp_b = 0;
        end else begin
            bit        e_en;
            int        e_line, e_ofs, per;
            bit [19:0] e_pay;
            bit        busy, go;
            bit [1:0]  ent;
            if (frame_start && p_ok) begin
                e_en = 1; e_line = p_line; e_ofs = p_ofs; e_pay = p_pay;
            end else begin
                e_en = l_en; e_line = l_line; e_ofs = l_ofs; e_pay = l_pay;
            end
            busy = (q.size() != 0);
            if (busy) ent = q.pop_front(); else ent = 2'b00;
            go = !busy && line_start && e_en && (int'(line_cnt) == e_line) &&
                 (frame_start || !m_done);
            if (go) begin
                ent = 2'b00;
                per = mode_2x ? 4 : 2;
                for (int i = 0; i < e_ofs; i++) q.push_back(2'b00);
                for (int b = 19; b >= 0; b--)
                    for (int k = 0; k < per; k++) q.push_back({1'b1, e_pay[b]});
                m_done = 1;
            end else if (frame_start) begin
                m_done = 0;
            end
            exp_v = ent[1];
            exp_b = ent[0];
            if (frame_start && p_ok) begin
                l_en = 1; l_line = p_line; l_ofs = p_ofs; l_pay = p_pay;
            end
            if (wr_en && wr_addr == 3'd5 && wr_data[7]) begin
                p_ok = 1;
                p_line = {s_hi, s_lo};
                p_ofs = s_ofs;
                p_pay = {wr_data[3:0], s_pay[15:0]};
            end else if (frame_start) begin
                p_ok = 0;
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: s_lo = wr_data;
                    3'd1: s_hi = wr_data[1:0];
                    3'd2: s_ofs = wr_data;
                    3'd3: s_pay[7:0] = wr_data;
                    3'd4: s_pay[15:8] = wr_data;
                    3'd5: s_pay[19:16] = wr_data[3:0];
                    default: ;
                endcase
            end
            started = 1'b1;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (started && !rst) begin
            checks++;
            if (cgms_valid !== exp_v || cgms_bit !== exp_b) begin
                errors++;
                $display("FAIL %s/R10 t=%0t valid/bit actual %b%b expected %b%b",
                         cur_req, $time, cgms_valid, cgms_bit, exp_v, exp_b);
            end
            if (cgms_valid === 1'b1) vcnt++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_frame(input int wrap);
        for (int ln = 0; ln < NL; ln++) begin
            for (int px = 0; px < LLEN; px++) begin
                @(negedge clk);
                frame_start = (ln == 0 && px == 0);
                line_start  = (px == 0);
                line_cnt    = 10'(ln % wrap);
            end
        end
        @(negedge clk);
        frame_start = 1'b0;
        line_start  = 1'b0;
    endtask

    task automatic frame_expect(input int wrap, input int exp_cnt, input string req);
        vcnt = 0;
        run_frame(wrap);
        repeat (3) @(negedge clk);
        check(vcnt == exp_cnt, req, vcnt, exp_cnt);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet after reset
        check(cgms_valid == 1'b0 && cgms_bit == 1'b0, "R1", {cgms_valid, cgms_bit}, 0);
        cur_req = "R1";
        frame_expect(100, 0, "R1");

        // R2/R4: stage line 2, delay 5, payload, top with enable clear
        cur_req = "R4";
        wr(0, 2); wr(1, 0); wr(2, 5); wr(3, 8'hA5); wr(4, 8'h3C); wr(5, 8'h09);
        frame_expect(100, 0, "R4");

        // R3/R2/R7: commit and insert in 1x timing
        cur_req = "R3";
        wr(5, 8'h89);
        frame_expect(100, 40, "R3");
        cur_req = "R7";
        frame_expect(100, 40, "R7");

        // R4: lower-register writes alone do not change the packet
        cur_req = "R4";
        wr(3, 8'hFF); wr(2, 0);
        frame_expect(100, 40, "R4");
        wr(5, 8'h06);
        frame_expect(100, 40, "R4");

        // R8/R9: 2x timing, ignored top bits set, delay now zero
        cur_req = "R8";
        mode_2x = 1'b1;
        wr(5, 8'hF2);
        frame_expect(100, 80, "R8");
        cur_req = "R9";
        frame_expect(100, 80, "R9");

        // R5: commit arrives in the middle of the inserted line 2
        cur_req = "R5";
        wr(0, 1);
        wr(4, 8'h81);
        vcnt = 0;
        fork
            run_frame(100);
            begin
                repeat (2 * LLEN + 20) @(negedge clk);
                wr(5, 8'h8E);
            end
        join
        repeat (3) @(negedge clk);
        check(vcnt == 80, "R5", vcnt, 80);
        frame_expect(100, 80, "R5");

        // R5: line 0 shares its cycle with frame start, commit late in frame
        mode_2x = 1'b0;
        wr(0, 0); wr(2, 3);
        vcnt = 0;
        fork
            run_frame(100);
            begin
                repeat (4 * LLEN + 50) @(negedge clk);
                wr(5, 8'h83);
            end
        join
        repeat (3) @(negedge clk);
        check(vcnt == 40, "R5", vcnt, 40);
        frame_expect(100, 40, "R5");

        // R6: line counter repeats the selected value within one frame
        cur_req = "R6";
        wr(0, 1); wr(5, 8'h8B);
        frame_expect(2, 40, "R6");
        frame_expect(2, 40, "R6");

        // R1: reset again clears the live packet
        cur_req = "R1";
        @(negedge clk);
        rst = 1'b1;
        started = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        frame_expect(2, 0, "R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule